// File: doc/BRIEF.md
# System-Control Coprocessor Register Bank

This block holds the system-control registers reached through coprocessor move requests. Each request carries a 32-bit instruction word, a privilege flag, a direction bit and write data. The block takes the register number, the primary and secondary opcodes and the auxiliary register field from fixed bit positions of that word. It decides in the same cycle whether the combination is legal, and answers with either an accept or a reject.

An accepted read returns the selected register. An accepted write lands on the next clock edge, filtered through that register's keep mask and forced-one pattern. The secondary opcode picks one of two banks: zero selects the main bank and non-zero selects the alternate bank. Register 14 uses the auxiliary field to pick one of five debug breakpoint registers. When an accepted write flips the endian bit of the control register, a one-cycle mode-change pulse follows so the core can resynchronise.

Top module: `sysctl_cp_regs`

## Requirements
- R1: A request with priv_i low is rejected whatever its fields: reject_o high, accept_o low, rdata_o zero, no register changes.
- R2: A request whose primary opcode (instr_i[23:21]) is non-zero is rejected.
- R3: Fields are taken from instr_i as follows: register number [19:16], primary opcode [23:21], secondary opcode [7:5], auxiliary field [3:0]. Secondary opcode zero selects the main bank and any non-zero value selects the alternate bank.
- R4: After reset, main register 0 reads 0x69052000, alternate register 0 reads 0x0B1AA1AA, main register 1 reads 0x00000078, and every other register reads zero. All outputs are low while reset is held.
- R5: A write to main register 1 (control) stores bits 13:11, 9:7 and 2:0 from the data, forces bits 6:3 to one, and forces bits 31:14 and bit 10 to zero.
- R6: Write masks keep these bits: register 2 keeps [31:14]; register 3 keeps all bits; register 5 keeps [10:9] and [7:0]; register 6 keeps all bits; register 9 keeps [0]; register 13 keeps [31:25]. Cleared bits read back zero.
- R7: Alternate register 1 keeps only bits 5:4 and 1:0. Writes to main register 0 and to alternate register 0 are accepted and have no effect.
- R8: Register 14 requires secondary opcode 0. The auxiliary field selects a debug register: 0 and 3 are the two data breakpoints, 4 is breakpoint control, 8 and 9 are the two instruction breakpoints. All five are fully writable. Any other field value is rejected.
- R9: Register 15 is legal only with auxiliary field 1 and secondary opcode 0, and it keeps bits 13:0.
- R10: Registers 0 and 1 need auxiliary field 0 and accept any secondary opcode. Registers 2, 3, 5, 6, 9 and 13 need auxiliary field 0 and secondary opcode 0. Registers 4, 7, 8, 10, 11 and 12 are always rejected.
- R11: A rejected request changes no register and returns zero read data. accept_o and reject_o are combinational, mutually exclusive, and exactly one is high while req_i is high.
- R12: An accepted write to the control register that changes bit 7 raises endian_chg_o for exactly the one cycle after the write edge. Any other write leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request valid |
| wr_i | input | 1 | 1 = move to coprocessor (write), 0 = move from (read) |
| instr_i | input | 32 | Instruction word holding the register and opcode fields |
| priv_i | input | 1 | High when the requester is privileged |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data; zero unless an accepted read |
| accept_o | output | 1 | Request accepted this cycle |
| reject_o | output | 1 | Request rejected this cycle |
| endian_chg_o | output | 1 | One-cycle pulse after a write that flips the control endian bit |

## Verification
A wrong mask or forced pattern in a register only shows on the next accepted read of that register. For that reason, every write sweep is followed by a read sweep over all 2048 field combinations. A single misplaced keep bit then shows as a read-data mismatch within a few thousand cycles. A wrong legality decision shows in the same cycle as a flipped accept or reject. A wrong bank or debug selection shows up as data aliasing between registers at the next read. A stale endian shadow bit shows as a missing or spurious pulse one cycle after the write.

// File: rtl/cp_sys_pkg.sv
package cp_sys_pkg;

  localparam int unsigned XLEN      = 32;
  localparam int unsigned REG_W     = 4;
  localparam int unsigned OPC_W     = 3;
  localparam int unsigned AUX_W     = 4;
  // instruction field positions (decoded by the requesting core)
  localparam int unsigned REG_LSB   = 16;
  localparam int unsigned OP1_LSB   = 21;
  localparam int unsigned OP2_LSB   = 5;
  localparam int unsigned AUX_LSB   = 0;
  localparam int unsigned ENDIAN_BIT = 7;

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [4:0] {
    SL_ID, SL_CTYPE, SL_CTRL, SL_AUX, SL_TTB, SL_DAC, SL_FSR, SL_FAR,
    SL_DLCK, SL_PID, SL_DBA0, SL_DBA1, SL_DBCTL, SL_IBA0, SL_IBA1, SL_CPAR,
    SL_NONE
  } slot_e;

  localparam int unsigned NUM_SLOTS = 16;

  function automatic word_t slot_keep(slot_e s);
    word_t k;
    case (s)
      SL_CTRL:  k = 32'h0000_3B87;
      SL_AUX:   k = 32'h0000_0033;
      SL_TTB:   k = 32'hFFFF_C000;
      SL_FSR:   k = 32'h0000_06FF;
      SL_DLCK:  k = 32'h0000_0001;
      SL_PID:   k = 32'hFE00_0000;
      SL_CPAR:  k = 32'h0000_3FFF;
      SL_DAC, SL_FAR, SL_DBA0, SL_DBA1,
      SL_DBCTL, SL_IBA0, SL_IBA1: k = '1;
      default:  k = '0;
    endcase
    return k;
  endfunction

  function automatic word_t slot_force(slot_e s);
    return (s == SL_CTRL) ? 32'h0000_0078 : '0;
  endfunction

  function automatic word_t slot_reset(slot_e s);
    word_t r;
    case (s)
      SL_ID:    r = 32'h6905_2000;
      SL_CTYPE: r = 32'h0B1A_A1AA;
      SL_CTRL:  r = 32'h0000_0078;
      default:  r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cp_sys_dec.sv
module cp_sys_dec
  import cp_sys_pkg::*;
(
  input  logic [XLEN-1:0] instr_i,
  input  logic            priv_i,
  output slot_e           slot_o,
  output logic            legal_o
);

  logic [REG_W-1:0] reg_n;
  logic [OPC_W-1:0] op1, op2;
  logic [AUX_W-1:0] aux;
  logic             alt_bank;
  logic             plain;
  logic             unused_bits;

  assign reg_n    = instr_i[REG_LSB +: REG_W];
  assign op1      = instr_i[OP1_LSB +: OPC_W];
  assign op2      = instr_i[OP2_LSB +: OPC_W];
  assign aux      = instr_i[AUX_LSB +: AUX_W];
  assign alt_bank = (op2 != '0);
  assign plain    = (aux == '0) && !alt_bank;
  assign unused_bits = ^{instr_i[31:24], instr_i[20], instr_i[15:8], instr_i[4]};

  always_comb begin
    slot_o = SL_NONE;
    unique case (reg_n)
      4'd0:  if (aux == '0) slot_o = alt_bank ? SL_CTYPE : SL_ID;
      4'd1:  if (aux == '0) slot_o = alt_bank ? SL_AUX : SL_CTRL;
      4'd2:  if (plain) slot_o = SL_TTB;
      4'd3:  if (plain) slot_o = SL_DAC;
      4'd5:  if (plain) slot_o = SL_FSR;
      4'd6:  if (plain) slot_o = SL_FAR;
      4'd9:  if (plain) slot_o = SL_DLCK;
      4'd13: if (plain) slot_o = SL_PID;
      4'd14: if (!alt_bank) begin
        unique case (aux)
          4'd0:    slot_o = SL_DBA0;
          4'd3:    slot_o = SL_DBA1;
          4'd4:    slot_o = SL_DBCTL;
          4'd8:    slot_o = SL_IBA0;
          4'd9:    slot_o = SL_IBA1;
          default: slot_o = SL_NONE;
        endcase
      end
      4'd15: if (aux == 4'd1 && !alt_bank) slot_o = SL_CPAR;
      default: slot_o = SL_NONE;
    endcase
  end

  assign legal_o = priv_i && (op1 == '0) && (slot_o != SL_NONE);

endmodule

// File: rtl/cp_sys_bank.sv
module cp_sys_bank
  import cp_sys_pkg::*;
#(
  parameter int unsigned NSLOT = NUM_SLOTS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  slot_e           slot_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata_o,
  output logic [XLEN-1:0] ctrl_o
);

  word_t q [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam slot_e SL    = slot_e'(g);
    localparam word_t KEEP  = slot_keep(SL);
    localparam word_t FORCE = slot_force(SL);
    localparam word_t RSTV  = slot_reset(SL);
    if (KEEP == '0) begin : g_ro
      assign q[g] = RSTV;
    end else begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                      q[g] <= RSTV;
        else if (we_i && slot_i == SL)    q[g] <= (wdata_i & KEEP) | FORCE;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < int'(NSLOT); i++)
      if (slot_i == slot_e'(i)) rdata_o = q[i];
  end

  assign ctrl_o = q[int'(SL_CTRL)];

  assert_ctrl_forced_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[6:3] == 4'hF && ctrl_o[31:14] == '0 && !ctrl_o[10]);

  assert_ro_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && slot_i == SL_ID |-> rdata_o == 32'h6905_2000);

endmodule

// File: rtl/cp_sys_mode.sv
module cp_sys_mode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_we_i,
  input  logic old_bit_i,
  input  logic new_bit_i,
  output logic pulse_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= ctrl_we_i && (old_bit_i != new_bit_i);
  end

endmodule

// File: rtl/sysctl_cp_regs.sv
module sysctl_cp_regs
  import cp_sys_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            wr_i,
  input  logic [XLEN-1:0] instr_i,
  input  logic            priv_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata_o,
  output logic            accept_o,
  output logic            reject_o,
  output logic            endian_chg_o
);

  slot_e     slot;
  logic      legal;
  logic      we;
  word_t     bank_rd;
  word_t     ctrl_q;

  cp_sys_dec u_dec (
    .instr_i (instr_i),
    .priv_i  (priv_i),
    .slot_o  (slot),
    .legal_o (legal)
  );

  assign accept_o = req_i && legal;
  assign reject_o = req_i && !legal;
  assign we       = accept_o && wr_i;

  cp_sys_bank #(.NSLOT(NUM_SLOTS)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .slot_i  (slot),
    .wdata_i (wdata_i),
    .rdata_o (bank_rd),
    .ctrl_o  (ctrl_q)
  );

  assign rdata_o = (accept_o && !wr_i) ? bank_rd : '0;

  cp_sys_mode u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_we_i (we && slot == SL_CTRL),
    .old_bit_i (ctrl_q[ENDIAN_BIT]),
    .new_bit_i (wdata_i[ENDIAN_BIT]),
    .pulse_o   (endian_chg_o)
  );

  assert_user_reject_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !priv_i |-> reject_o && rdata_o == '0);

  assert_op1_reject_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && instr_i[OP1_LSB +: OPC_W] != '0 |-> reject_o);

  assert_dbg_sel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o && instr_i[REG_LSB +: REG_W] == 4'd14 |->
      instr_i[OP2_LSB +: OPC_W] == '0 &&
      (instr_i[3:0] inside {4'd0, 4'd3, 4'd4, 4'd8, 4'd9}));

  assert_cpar_sel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o && instr_i[REG_LSB +: REG_W] == 4'd15 |-> instr_i[3:0] == 4'd1);

  assert_resp_onehot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_o && reject_o) && ((accept_o || reject_o) == req_i));

  assert_reject_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |=> $stable(ctrl_q));

  assert_endian_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    endian_chg_o |-> ctrl_q[ENDIAN_BIT] != $past(ctrl_q[ENDIAN_BIT]));

endmodule

// File: tb/sysctl_cp_regs_tb.sv
`timescale 1ns/1ps
module sysctl_cp_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        req, wr, priv;
  logic [31:0] instr, wdata;
  logic [31:0] rdata;
  logic        accept, reject, endian_chg;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [48];

  always #2 clk = ~clk;

  sysctl_cp_regs dut_i (
    .clk_i (clk), .rst_ni (rst_ni), .req_i (req), .wr_i (wr),
    .instr_i (instr), .priv_i (priv), .wdata_i (wdata),
    .rdata_o (rdata), .accept_o (accept), .reject_o (reject),
    .endian_chg_o (endian_chg)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
    end
  endtask

  // R10, R8, R9, R1, R2: legality from the requirements
  function automatic bit exp_legal(int r, int o1, int o2, int cm, bit pv);
    if (!pv || o1 != 0) return 1'b0;
    case (r)
      0, 1:               return cm == 0;
      2, 3, 5, 6, 9, 13:  return cm == 0 && o2 == 0;
      14:                 return o2 == 0 && (cm == 0 || cm == 3 || cm == 4 || cm == 8 || cm == 9);
      15:                 return cm == 1 && o2 == 0;
      default:            return 1'b0;
    endcase
  endfunction

  function automatic int midx(int r, int o2, int cm);
    if (r == 14) return 32 + cm;
    if (o2 != 0) return 16 + r;
    return r;
  endfunction

  // R5, R6, R7, R8, R9 keep masks
  function automatic logic [31:0] keepv(int r, int o2);
    if (o2 != 0) return (r == 1) ? 32'h33 : 32'h0;
    case (r)
      1:  return 32'h3B87;
      2:  return 32'hFFFF_C000;
      3, 6, 14: return 32'hFFFF_FFFF;
      5:  return 32'h6FF;
      9:  return 32'h1;
      13: return 32'hFE00_0000;
      15: return 32'h3FFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] mkinstr(int r, int o1, int o2, int cm);
    return (32'(o1) << 21) | (32'(r) << 16) | (32'(o2) << 5) | 32'(cm);
  endfunction

  task automatic acc(input bit w, input int r, input int o1, input int o2,
                     input int cm, input bit pv, input logic [31:0] wd, input string rq);
    bit ok, flip;
    logic [31:0] er, nv;
    int k;
    @(negedge clk);
    req = 1'b1; wr = w; priv = pv; wdata = wd; instr = mkinstr(r, o1, o2, cm);
    #1;
    ok = exp_legal(r, o1, o2, cm, pv);
    k  = midx(r, o2, cm);
    chk(accept == ok && reject == !ok, {rq, " accept/reject"}, {30'b0, accept, reject}, {30'b0, ok, !ok});
    er = (ok && !w) ? mdl[k] : 32'h0;
    chk(rdata == er, {rq, " rdata"}, rdata, er);
    flip = 1'b0;
    if (ok && w && keepv(r, o2) != 0) begin
      nv = (wd & keepv(r, o2)) | ((r == 1 && o2 == 0) ? 32'h78 : 32'h0);
      flip = (r == 1 && o2 == 0) && (nv[7] != mdl[k][7]);
      mdl[k] = nv;
    end
    @(posedge clk);
    #1;
    chk(endian_chg == flip, "R12 endian pulse", {31'b0, endian_chg}, {31'b0, flip});
  endtask

  task automatic idle;
    @(negedge clk);
    req = 1'b0; wr = 1'b0;
  endtask

  task automatic sweep(input bit w, input logic [31:0] base, input string rq);
    for (int r = 0; r < 16; r++)
      for (int o2 = 0; o2 < 8; o2++)
        for (int cm = 0; cm < 16; cm++)
          acc(w, r, 0, o2, cm, 1'b1, base ^ (32'(r) * 32'h0101_0101) ^ (32'(cm) << 12), rq);
    idle();
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 48; i++) mdl[i] = 32'h0;
    mdl[0] = 32'h6905_2000; mdl[16] = 32'h0B1A_A1AA; mdl[1] = 32'h78;
    rst_ni = 1'b0; req = 1'b0; wr = 1'b0; priv = 1'b1; instr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!accept && !reject && rdata == 0 && !endian_chg, "R4 reset outputs",
        {29'b0, accept, reject, endian_chg}, 32'h0);
    rst_ni = 1'b1;

    sweep(1'b0, 32'h0, "R4 R10 reset read sweep");

    // R1 user mode rejected, no change
    for (int r = 0; r < 16; r++) begin
      acc(1'b1, r, 0, 0, (r == 15) ? 1 : 0, 1'b0, 32'hFFFF_FFFF, "R1 user write");
      acc(1'b0, r, 0, 0, (r == 15) ? 1 : 0, 1'b0, 32'h0, "R1 user read");
    end
    // R2 non-zero primary opcode
    for (int o1 = 1; o1 < 8; o1++) begin
      acc(1'b1, 3, o1, 0, 0, 1'b1, 32'hDEAD_BEEF, "R2 op1 write");
      acc(1'b1, 1, o1, 0, 0, 1'b1, 32'h80, "R2 op1 ctrl write");
    end
    sweep(1'b0, 32'h0, "R11 post-reject read sweep");

    // R5 R12 explicit endian sequence
    acc(1'b1, 1, 0, 0, 0, 1'b1, 32'h0000_0080, "R12 set endian");
    acc(1'b1, 1, 0, 0, 0, 1'b1, 32'hFFFF_FF80, "R12 same endian");
    acc(1'b0, 1, 0, 0, 0, 1'b1, 32'h0, "R5 ctrl readback");
    acc(1'b1, 1, 0, 0, 0, 1'b1, 32'h0, "R12 clear endian");
    acc(1'b1, 1, 0, 0, 0, 1'b0, 32'h80, "R12 user no pulse");
    // R7 read-only ids
    acc(1'b1, 0, 0, 0, 0, 1'b1, 32'h1234_5678, "R7 id write");
    acc(1'b1, 0, 0, 3, 0, 1'b1, 32'h1234_5678, "R7 ctype write");
    acc(1'b0, 0, 0, 0, 0, 1'b1, 32'h0, "R7 id read");
    acc(1'b0, 0, 0, 5, 0, 1'b1, 32'h0, "R7 ctype read");
    idle();

    sweep(1'b1, 32'hFFFF_FFFF, "R6 R8 R9 write ones");
    sweep(1'b0, 32'h0, "R3 R6 R8 R9 read ones");
    sweep(1'b1, 32'h0000_0000, "R6 R7 write zero");
    sweep(1'b0, 32'h0, "R5 R6 read zero");
    sweep(1'b1, 32'h5A3C_96E1, "R8 R10 write pattern");
    sweep(1'b0, 32'h0, "R3 R8 R10 read pattern");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule